// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block filters transactions on their way into a memory controller. Each request carries a byte address, a 12-bit transaction ID, a port number and a 2-bit security attribute. The block checks the request against a table of programmable rules and returns a registered accept or reject decision, together with the index of the rule that decided it.

Software builds each rule in three staging registers: an address-block range, an ID range and an attribute word. Writing the rule-access register with a rule index and a write strobe bit copies the staging registers into that table entry. Writing it with a read strobe bit copies the entry back into the staging registers, so software can inspect it. When no rule matches, a per-port default mask decides the outcome. Addresses are compared in 1 MiB blocks, using address bits 31:20.

Top module: `prot_filter`

## Requirements
- R1: The table holds 20 rules, indexed 0 to 19. After reset every rule is invalid, and the staging registers, the selected index and the default mask all read 0. A request made before any programming is therefore accepted with no hit.
- R2: Configuration offsets are 0 for rule access, 1 for range, 2 for ID, 3 for attribute and 4 for the default mask. In the rule-access word, bits 4:0 hold the index, bit 5 is the write strobe and bit 6 is the read strobe. A write strobe copies the staging registers into the selected rule on that clock edge. If both strobe bits are set, the write is performed and the read is not.
- R3: A read strobe loads the selected rule into the staging registers, and the staging registers then read back exactly the fields that were written. The field layouts are:
  - range word: start block in bits 11:0, end block in bits 23:12;
  - ID word: low ID in bits 11:0, high ID in bits 23:12;
  - attribute word: security in bits 1:0, valid at bit 2, port mask in bits 12:3, result at bit 13.
  
  Offset 0 reads back the index alone.
- R4: Writing the rule-access register leaves the table unchanged in two cases: when bit 5 is clear, or when the index is 20 or higher.
- R5: A rule matches only when all of these hold:
  - it is valid;
  - address bits 31:20 lie between its start and end blocks, both inclusive;
  - the ID lies between its low and high IDs, both inclusive;
  - its port mask has the request's port bit set;
  - its security field is 0, or equals the request's attribute.
- R6: A matching rule decides the request. A result bit of 0 accepts and 1 rejects. The response reports a hit and the rule's index.
- R7: When several rules match, the one with the lowest index decides.
- R8: When no rule matches, bit p of the default mask decides for port p: 0 accepts and 1 rejects. The hit flag is 0 and the reported index is 0.
- R9: A request from a port numbered 10 or higher never matches a rule and is rejected with no hit.
- R10: The response appears with `resp_valid` high in the cycle after the request is sampled, and `resp_valid` is low after any cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Read data of the register at `cfg_addr` (combinational) |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_id | input | 12 | Request transaction ID |
| req_port | input | 4 | Request port number |
| req_sec | input | 2 | Request security attribute |
| resp_valid | output | 1 | Decision present |
| resp_reject | output | 1 | 1 rejects, 0 accepts |
| resp_hit | output | 1 | A rule decided the request |
| resp_rule | output | 5 | Index of the deciding rule, or 0 when there is no hit |

## Verification
The bench builds the block with its default values: 20 rules, 10 ports and a 32-bit address. With these values the highest index (19), the first illegal index (20) and the first illegal port (10) are all reachable at the ports. The chosen rules overlap in both directions of priority, and one rule covers a single block and a single ID. Together they exercise inclusive range edges on both bounds, the security wildcard and the default mask with mixed port bits.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int BLK_W      = 12;
    localparam int ID_W       = 12;
    localparam int SEC_W      = 2;
    localparam int NUM_PORTS  = 10;
    localparam int CFG_DW     = 2 * BLK_W;
    localparam int CFG_AW     = 3;

    // attribute word layout
    localparam int ATTR_VALID = SEC_W;
    localparam int ATTR_MASK  = SEC_W + 1;
    localparam int ATTR_RES   = ATTR_MASK + NUM_PORTS;
    localparam int ATTR_W     = ATTR_RES + 1;

    // strobe positions in the rule-access word
    localparam int STB_WR     = 5;
    localparam int STB_RD     = 6;

    typedef enum logic [CFG_AW-1:0] {
        REG_ACCESS  = 3'd0,
        REG_RANGE   = 3'd1,
        REG_IDS     = 3'd2,
        REG_ATTR    = 3'd3,
        REG_DEFAULT = 3'd4
    } cfg_reg_e;

    typedef struct packed {
        logic [BLK_W-1:0]     blk_hi;
        logic [BLK_W-1:0]     blk_lo;
        logic [ID_W-1:0]      id_hi;
        logic [ID_W-1:0]      id_lo;
        logic                 result;
        logic [NUM_PORTS-1:0] ports;
        logic                 valid;
        logic [SEC_W-1:0]     sec;
    } rule_t;

endpackage

// File: rtl/prot_cfg.sv
module prot_cfg
    import prot_pkg::*;
#(
    parameter int NUM_RULES = 20,
    localparam int IDX_W    = $clog2(NUM_RULES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    output logic [CFG_DW-1:0]         cfg_rdata,
    output rule_t [NUM_RULES-1:0]     rules_o,
    output logic [NUM_PORTS-1:0]      dflt_o
);

    typedef struct packed {
        rule_t [NUM_RULES-1:0] tbl;
        rule_t                 stage;
        logic [IDX_W-1:0]      idx;
        logic [NUM_PORTS-1:0]  dflt;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic [IDX_W-1:0] acc_idx;
    logic             idx_ok;
    logic             acc_wr;
    rule_t            peek_rule;

    assign acc_idx   = cfg_wdata[IDX_W-1:0];
    assign idx_ok    = int'(acc_idx) < NUM_RULES;
    assign acc_wr    = cfg_we && (cfg_reg_e'(cfg_addr) == REG_ACCESS);
    assign peek_rule = st_q.tbl[acc_idx];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_reg_e'(cfg_addr))
                REG_ACCESS: begin
                    st_d.idx = acc_idx;
                    if (idx_ok) begin
                        if (cfg_wdata[STB_WR]) begin
                            st_d.tbl[acc_idx] = st_q.stage;
                        end else if (cfg_wdata[STB_RD]) begin
                            st_d.stage = st_q.tbl[acc_idx];
                        end
                    end
                end
                REG_RANGE: begin
                    st_d.stage.blk_lo = cfg_wdata[BLK_W-1:0];
                    st_d.stage.blk_hi = cfg_wdata[2*BLK_W-1:BLK_W];
                end
                REG_IDS: begin
                    st_d.stage.id_lo = cfg_wdata[ID_W-1:0];
                    st_d.stage.id_hi = cfg_wdata[2*ID_W-1:ID_W];
                end
                REG_ATTR: begin
                    st_d.stage.sec    = cfg_wdata[SEC_W-1:0];
                    st_d.stage.valid  = cfg_wdata[ATTR_VALID];
                    st_d.stage.ports  = cfg_wdata[ATTR_MASK +: NUM_PORTS];
                    st_d.stage.result = cfg_wdata[ATTR_RES];
                end
                REG_DEFAULT: begin
                    st_d.dflt = cfg_wdata[NUM_PORTS-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_reg_e'(cfg_addr))
            REG_ACCESS:  cfg_rdata = CFG_DW'(st_q.idx);
            REG_RANGE:   cfg_rdata = {st_q.stage.blk_hi, st_q.stage.blk_lo};
            REG_IDS:     cfg_rdata = {st_q.stage.id_hi, st_q.stage.id_lo};
            REG_ATTR:    cfg_rdata = CFG_DW'({st_q.stage.result, st_q.stage.ports,
                                              st_q.stage.valid, st_q.stage.sec});
            REG_DEFAULT: cfg_rdata = CFG_DW'(st_q.dflt);
            default:     cfg_rdata = '0;
        endcase
    end

    assign rules_o = st_q.tbl;
    assign dflt_o  = st_q.dflt;

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !cfg_wdata[STB_WR]) |=> $stable(st_q.tbl)); // R4

    AST_BAD_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !idx_ok) |=> $stable(st_q.tbl)); // R4

    AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && idx_ok && cfg_wdata[STB_RD] && !cfg_wdata[STB_WR])
        |=> (st_q.stage == $past(peek_rule))); // R3

    AST_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && idx_ok && cfg_wdata[STB_WR])
        |=> (st_q.tbl[$past(acc_idx)] == $past(st_q.stage))); // R2

endmodule

// File: rtl/prot_match.sv
module prot_match
    import prot_pkg::*;
#(
    parameter int NUM_RULES = 20,
    localparam int IDX_W    = $clog2(NUM_RULES),
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  rule_t [NUM_RULES-1:0] rules,
    input  logic [NUM_PORTS-1:0]  dflt,
    input  logic [BLK_W-1:0]      blk,
    input  logic [ID_W-1:0]       id,
    input  logic [PORT_W-1:0]     port,
    input  logic [SEC_W-1:0]      sec,
    output logic                  reject,
    output logic                  hit,
    output logic [IDX_W-1:0]      win_idx
);

    logic                 port_ok;
    logic [NUM_RULES-1:0] hits;
    logic                 win_res;

    assign port_ok = int'(port) < NUM_PORTS;

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        logic in_blk, in_id, sec_ok;
        assign in_blk = (blk >= rules[g].blk_lo) && (blk <= rules[g].blk_hi);
        assign in_id  = (id >= rules[g].id_lo) && (id <= rules[g].id_hi);
        assign sec_ok = (rules[g].sec == '0) || (rules[g].sec == sec);
        assign hits[g] = rules[g].valid && port_ok && rules[g].ports[port]
                         && in_blk && in_id && sec_ok;
    end

    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_res = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit     = 1'b1;
                win_idx = IDX_W'(i);
                win_res = rules[i].result;
            end
        end
        if (hit) begin
            reject = win_res;
        end else begin
            reject = !port_ok || dflt[port];
        end
    end

endmodule

// File: rtl/prot_filter.sv
module prot_filter
    import prot_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = $clog2(NUM_RULES),
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic [PORT_W-1:0] req_port,
    input  logic [SEC_W-1:0]  req_sec,
    output logic              resp_valid,
    output logic              resp_reject,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_rule
);

    typedef struct packed {
        logic             valid;
        logic             reject;
        logic             hit;
        logic [IDX_W-1:0] rule;
    } resp_t;

    rule_t [NUM_RULES-1:0] rules;
    logic [NUM_PORTS-1:0]  dflt;
    logic                  m_reject, m_hit;
    logic [IDX_W-1:0]      m_idx;
    logic                  unused_low;
    resp_t                 rsp_d, rsp_q;

    assign unused_low = ^req_addr[ADDR_W-BLK_W-1:0];

    prot_cfg #(.NUM_RULES(NUM_RULES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rules_o   (rules),
        .dflt_o    (dflt)
    );

    prot_match #(.NUM_RULES(NUM_RULES)) u_match (
        .rules   (rules),
        .dflt    (dflt),
        .blk     (req_addr[ADDR_W-1 -: BLK_W]),
        .id      (req_id),
        .port    (req_port),
        .sec     (req_sec),
        .reject  (m_reject),
        .hit     (m_hit),
        .win_idx (m_idx)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.reject = m_reject;
            rsp_d.hit    = m_hit;
            rsp_d.rule   = m_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign resp_valid  = rsp_q.valid;
    assign resp_reject = rsp_q.reject;
    assign resp_hit    = rsp_q.hit;
    assign resp_rule   = rsp_q.rule;

    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R10

    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R10

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_port) >= NUM_PORTS) |=> (resp_reject && !resp_hit)); // R9

    AST_HIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (int'(resp_rule) < NUM_RULES)); // R6

    AST_NOHIT_RULE0: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_rule == '0)); // R8

endmodule

// File: tb/prot_filter_test.sv
module prot_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_id = '0;
    logic [3:0]  req_port = '0;
    logic [1:0]  req_sec = '0;
    logic        resp_valid, resp_reject, resp_hit;
    logic [4:0]  resp_rule;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prot_filter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id),
        .req_port(req_port), .req_sec(req_sec),
        .resp_valid(resp_valid), .resp_reject(resp_reject),
        .resp_hit(resp_hit), .resp_rule(resp_rule)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [11:0] id;
        logic [3:0]  port;
        logic [1:0]  sec;
        logic        rej;
        logic        hit;
        logic [4:0]  rule;
    } vec_t;

    // default mask 0x0F0: ports 4..7 reject when unmatched
    localparam vec_t VECS [0:16] = '{
        '{32'h0000_0000, 12'h000, 4'd0, 2'd0, 1'b0, 1'b1, 5'd2 },  // R5 low edge
        '{32'h0FFF_FFFF, 12'hFFF, 4'd9, 2'd3, 1'b0, 1'b1, 5'd2 },  // R5 high edge, sec wildcard
        '{32'h1000_0000, 12'h000, 4'd0, 2'd0, 1'b0, 1'b0, 5'd0 },  // R8 accept
        '{32'h1000_0000, 12'h000, 4'd5, 2'd0, 1'b1, 1'b0, 5'd0 },  // R8 reject
        '{32'h0850_0000, 12'h015, 4'd2, 2'd0, 1'b0, 1'b1, 5'd2 },  // R7 lower wins
        '{32'h2000_0000, 12'h005, 4'd7, 2'd1, 1'b1, 1'b1, 5'd1 },  // R6 reject rule
        '{32'h2000_0000, 12'h005, 4'd7, 2'd2, 1'b1, 1'b0, 5'd0 },  // R5 sec mismatch
        '{32'h2000_0000, 12'h006, 4'd7, 2'd1, 1'b1, 1'b0, 5'd0 },  // R5 id outside
        '{32'h2000_0000, 12'h005, 4'd3, 2'd1, 1'b0, 1'b0, 5'd0 },  // R5 port not in mask
        '{32'h3000_0000, 12'h100, 4'd0, 2'd0, 1'b0, 1'b1, 5'd4 },  // R7 rule4 over rule7
        '{32'h3000_0000, 12'h0FF, 4'd0, 2'd0, 1'b1, 1'b1, 5'd7 },  // R7 falls to rule7
        '{32'h30F0_0000, 12'h1FF, 4'd0, 2'd0, 1'b1, 1'b1, 5'd7 },  // R6
        '{32'hFFFF_FFFF, 12'h000, 4'd9, 2'd0, 1'b0, 1'b1, 5'd19},  // R6 top index
        '{32'hFFFF_FFFF, 12'h000, 4'd8, 2'd0, 1'b0, 1'b0, 5'd0 },  // R8
        '{32'h0000_0000, 12'h000, 4'd10, 2'd0, 1'b1, 1'b0, 5'd0 }, // R9
        '{32'h3FF0_0000, 12'h000, 4'd4, 2'd0, 1'b1, 1'b1, 5'd7 },  // R5 end block
        '{32'h4000_0000, 12'h000, 4'd4, 2'd0, 1'b1, 1'b0, 5'd0 }   // R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [23:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [23:0] attr(input logic [1:0] s, input logic v,
                                         input logic [9:0] m, input logic r);
        return {10'd0, r, m, v, s};
    endfunction

    task automatic prog(input int idx, input logic [11:0] blo, input logic [11:0] bhi,
                        input logic [11:0] ilo, input logic [11:0] ihi,
                        input logic [23:0] at);
        cfg_write(3'd1, {bhi, blo});
        cfg_write(3'd2, {ihi, ilo});
        cfg_write(3'd3, at);
        cfg_write(3'd0, 24'(idx) | 24'h20);
    endtask

    task automatic send(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                        input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_id = id; req_port = p; req_sec = s;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {24'd0, resp_valid, resp_reject, resp_hit, resp_rule}, {24'd0, exp});
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            cfg_read(3'(a), rd);
            check($sformatf("R1 reg%0d after reset", a), {8'd0, rd}, 32'd0);
        end
        check("R10 no response when idle", {31'd0, resp_valid}, 32'd0);
        send(32'h0000_0000, 12'h0, 4'd5, 2'd0, 8'b1000_0000, "R1 unprogrammed accept");
        @(negedge clk);
        check("R10 valid drops after request", {31'd0, resp_valid}, 32'd0);
        cfg_write(3'd0, 24'd19 | 24'h40);
        cfg_read(3'd3, rd);
        check("R1 rule19 invalid after reset", {8'd0, rd}, 32'd0);

        // program table
        prog(2,  12'h000, 12'h0FF, 12'h000, 12'hFFF, attr(2'd0, 1'b1, 10'h3FF, 1'b0));
        prog(5,  12'h080, 12'h08F, 12'h010, 12'h01F, attr(2'd0, 1'b1, 10'h004, 1'b1));
        prog(1,  12'h200, 12'h200, 12'h005, 12'h005, attr(2'd1, 1'b1, 10'h080, 1'b1));
        prog(7,  12'h300, 12'h3FF, 12'h000, 12'hFFF, attr(2'd0, 1'b1, 10'h3FF, 1'b1));
        prog(4,  12'h300, 12'h300, 12'h100, 12'h1FF, attr(2'd0, 1'b1, 10'h001, 1'b0));
        prog(19, 12'hF00, 12'hFFF, 12'h000, 12'hFFF, attr(2'd0, 1'b1, 10'h200, 1'b0));
        cfg_write(3'd4, 24'h0F0);
        cfg_read(3'd4, rd);
        check("R2 default mask readback", {8'd0, rd}, 32'h0F0);

        // R3 readback of rule 5
        cfg_write(3'd1, 24'h0);
        cfg_write(3'd0, 24'd5 | 24'h40);
        cfg_read(3'd0, rd); check("R3 index readback", {8'd0, rd}, 32'd5);
        cfg_read(3'd1, rd); check("R3 range readback", {8'd0, rd}, 32'h08F080);
        cfg_read(3'd2, rd); check("R3 id readback", {8'd0, rd}, 32'h01F010);
        cfg_read(3'd3, rd); check("R3 attr readback", {8'd0, rd}, 32'h002024);
        cfg_write(3'd0, 24'd1 | 24'h40);
        cfg_read(3'd3, rd); check("R3 rule1 attr", {8'd0, rd}, 32'h002405);

        // vector table: R5 R6 R7 R8 R9
        for (int i = 0; i <= 16; i++) begin
            send(VECS[i].addr, VECS[i].id, VECS[i].port, VECS[i].sec,
                 {1'b1, VECS[i].rej, VECS[i].hit, VECS[i].rule},
                 $sformatf("R5-9 vector %0d", i));
        end

        // R4 access write without strobe bits
        cfg_write(3'd1, 24'h0);
        cfg_write(3'd2, 24'h0);
        cfg_write(3'd3, 24'h0);
        cfg_write(3'd0, 24'd5);
        cfg_write(3'd0, 24'd5 | 24'h40);
        cfg_read(3'd3, rd); check("R4 no strobe keeps rule5", {8'd0, rd}, 32'h002024);

        // R4 index out of range ignored
        cfg_write(3'd1, {12'h1FF, 12'h100});
        cfg_write(3'd2, {12'hFFF, 12'h000});
        cfg_write(3'd3, attr(2'd0, 1'b1, 10'h3FF, 1'b0));
        cfg_write(3'd0, 24'd20 | 24'h20);
        send(32'h1000_0000, 12'h0, 4'd5, 2'd0, 8'b1100_0000, "R4 index 20 ignored");

        // R5 invalid rule never matches
        cfg_write(3'd3, attr(2'd0, 1'b0, 10'h3FF, 1'b0));
        cfg_write(3'd0, 24'd0 | 24'h20);
        send(32'h1000_0000, 12'h0, 4'd5, 2'd0, 8'b1100_0000, "R5 invalid rule0");

        // R2 valid write to index 0 takes effect
        cfg_write(3'd3, attr(2'd0, 1'b1, 10'h3FF, 1'b0));
        cfg_write(3'd0, 24'd0 | 24'h20);
        send(32'h1000_0000, 12'h0, 4'd5, 2'd0, 8'b1010_0000, "R2 rule0 written");

        // R1 cleared rule no longer matches
        cfg_write(3'd1, 24'h0);
        cfg_write(3'd2, 24'h0);
        cfg_write(3'd3, 24'h0);
        cfg_write(3'd0, 24'd2 | 24'h20);
        send(32'h0000_0000, 12'h0, 4'd0, 2'd0, 8'b1000_0000, "R1 cleared rule2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule